// File: doc/BRIEF.md
# Sector Write-Protect Arbiter

This block decides whether an access to one of the uniform 64 KB sectors of a flash array may proceed. Each request carries a byte address and an operation code (read, program, erase, or clear-status). The sector index is the upper part of the address. For program and erase, two hardware protect inputs are combined with a per-sector software write-lock bit. One input guards the highest sector. The other guards every other sector. For reads, only a per-sector software read-lock bit is consulted.

The protect inputs and the addressed sector's lock bits are captured in the cycle the request is presented. The verdict therefore belongs to the start of the operation, and any later movement of the pins or the lock registers does not change it. A denied access sets a sticky error flag. The flag stays set until a clear-status request is issued. The number of sectors is a parameter: 16 for the larger density, 8 for the smaller.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector's write-lock and read-lock bits are set (locked), `err_flag` is 0 and `resp_valid` is 0.
- R2: Operation codes on `req_op` are 00 read, 01 program, 10 erase and 11 clear-status. A read, program or erase request accepted on one rising edge produces `resp_valid` for exactly one cycle after the second rising edge. A clear-status request produces no response.
- R3: While `top_lock_n` is low at request time, program and erase of the highest sector (index NUM_SECTORS-1) are denied. `top_lock_n` has no effect on any other sector.
- R4: While `wp_n` is low at request time, program and erase of every sector except the highest are denied. `wp_n` has no effect on the highest sector.
- R5: A program or erase is granted only when the hardware input guarding that sector is high and the sector's software write-lock bit is clear.
- R6: A read is granted exactly when the sector's read-lock bit is clear. The protect inputs and the write-lock bit do not affect reads.
- R7: The protect inputs and lock bits are sampled in the request cycle. Changes to them in any later cycle, including a lock write in the cycle right after the request, do not alter that request's verdict.
- R8: Any denied response sets `err_flag`, which stays set through later grants until a clear-status request clears it. The flag falls after the second edge following the clear request.
- R9: A lock write (`lock_wr_en` high) loads `lock_wr_data` into the sector selected by `lock_wr_sector`, with bit 0 as write-lock and bit 1 as read-lock (1 = locked). No other sector changes. The sector index of a request is `req_addr[ADDR_W-1:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Byte address; upper SECT_W bits select the sector |
| top_lock_n | input | 1 | Low protects the highest sector against program/erase |
| wp_n | input | 1 | Low protects all other sectors against program/erase |
| lock_wr_en | input | 1 | Lock register write strobe |
| lock_wr_sector | input | SECT_W | Sector whose lock bits are written |
| lock_wr_data | input | 2 | {read-lock, write-lock} |
| resp_valid | output | 1 | Verdict is valid this cycle |
| resp_grant | output | 1 | 1 = operation may proceed, 0 = denied |
| err_flag | output | 1 | Sticky denial flag |

## Verification
The bench targets the boundary between the top sector and its neighbour under each pin setting. A design that swapped or merged the two protect inputs would grant or deny the wrong side of that boundary. It toggles the pins and rewrites a lock in the cycle right after a request. A design that samples late would then return the opposite verdict. It checks that reads ignore pins and write locks, and that a grant after a denial leaves the flag set. It also issues back-to-back requests, so that a pipeline dropping or merging a stage shows up as a lost or misaligned response.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_CLEAR = 2'b11
  } op_e;

  // bit 1: read lock, bit 0: write lock, 1 = locked
  typedef struct packed {
    logic rd_lock;
    logic wr_lock;
  } lock_t;

  localparam lock_t LOCK_RESET = '{rd_lock: 1'b1, wr_lock: 1'b1};

endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SECT_W-1:0] wr_sel,
  input  logic [1:0]        wr_data,
  input  logic [SECT_W-1:0] rd_sel,
  output lock_t             rd_lock
);

  lock_t bank_q [NUM_SECTORS];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sector
    logic  hit;
    lock_t bank_d;

    always_comb begin
      hit    = wr_en && (wr_sel == SECT_W'(g));
      bank_d = bank_q[g];
      if (hit) bank_d = lock_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[g] <= LOCK_RESET;
      else if (hit) bank_q[g] <= bank_d;
    end
  end

  always_comb begin
    rd_lock = LOCK_RESET;
    for (int i = 0; i < NUM_SECTORS; i++) begin
      if (rd_sel == SECT_W'(i)) rd_lock = bank_q[i];
    end
  end

endmodule

// File: rtl/sg_pin_gate.sv
module sg_pin_gate #(
  parameter int NUM_SECTORS = 16,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic [SECT_W-1:0] sector,
  input  logic              top_lock_n,
  input  logic              wp_n,
  output logic              hw_ok
);

  localparam logic [SECT_W-1:0] TOP_IDX = SECT_W'(NUM_SECTORS - 1);

  logic is_top;

  always_comb begin
    is_top = (sector == TOP_IDX);
    hw_ok  = is_top ? top_lock_n : wp_n;
  end

endmodule

// File: rtl/sg_verdict.sv
module sg_verdict
  import sg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  op_e   req_op,
  input  logic  hw_ok,
  input  lock_t lock,
  output logic  resp_valid,
  output logic  resp_grant,
  output logic  err_flag
);

  // capture stage: everything the verdict depends on, frozen at request time
  logic  cap_valid_q, cap_valid_d;
  op_e   cap_op_q,    cap_op_d;
  logic  cap_hw_q,    cap_hw_d;
  lock_t cap_lock_q,  cap_lock_d;

  logic  out_valid_q, out_valid_d;
  logic  out_grant_q, out_grant_d;
  logic  err_q,       err_d;
  logic  is_access, is_clear, allow;

  always_comb begin
    cap_valid_d = req_valid;
    cap_op_d    = req_op;
    cap_hw_d    = hw_ok;
    cap_lock_d  = lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid_q <= 1'b0;
      cap_op_q    <= OP_READ;
      cap_hw_q    <= 1'b0;
      cap_lock_q  <= LOCK_RESET;
    end else begin
      cap_valid_q <= cap_valid_d;
      if (req_valid) begin
        cap_op_q   <= cap_op_d;
        cap_hw_q   <= cap_hw_d;
        cap_lock_q <= cap_lock_d;
      end
    end
  end

  always_comb begin
    is_clear  = cap_valid_q && (cap_op_q == OP_CLEAR);
    is_access = cap_valid_q && (cap_op_q != OP_CLEAR);
    unique case (cap_op_q)
      OP_READ:           allow = !cap_lock_q.rd_lock;
      OP_PROG, OP_ERASE: allow = cap_hw_q && !cap_lock_q.wr_lock;
      default:           allow = 1'b0;
    endcase
    out_valid_d = is_access;
    out_grant_d = is_access && allow;
    err_d       = err_q;
    if (is_clear)                err_d = 1'b0;
    else if (is_access && !allow) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_grant_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      out_grant_q <= out_grant_d;
      err_q       <= err_d;
    end
  end

  assign resp_valid = out_valid_q;
  assign resp_grant = out_grant_q;
  assign err_flag   = err_q;

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter  int NUM_SECTORS = 16,
  parameter  int OFFSET_W    = 16,
  localparam int SECT_W      = $clog2(NUM_SECTORS),
  localparam int ADDR_W      = SECT_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              top_lock_n,
  input  logic              wp_n,
  input  logic              lock_wr_en,
  input  logic [SECT_W-1:0] lock_wr_sector,
  input  logic [1:0]        lock_wr_data,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              err_flag
);

  logic              rst_n_int;
  logic [SECT_W-1:0] req_sector;
  lock_t             sector_lock;
  logic              hw_ok;

  assign req_sector = req_addr[ADDR_W-1 -: SECT_W];

  sg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sg_lock_bank #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_lock_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (lock_wr_en),
    .wr_sel  (lock_wr_sector),
    .wr_data (lock_wr_data),
    .rd_sel  (req_sector),
    .rd_lock (sector_lock)
  );

  sg_pin_gate #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_pin_gate (
    .sector     (req_sector),
    .top_lock_n (top_lock_n),
    .wp_n       (wp_n),
    .hw_ok      (hw_ok)
  );

  sg_verdict u_verdict (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_op     (op_e'(req_op)),
    .hw_ok      (hw_ok),
    .lock       (sector_lock),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .err_flag   (err_flag)
  );

endmodule

// File: rtl/sector_guard_checker.sv
module sector_guard_checker #(
  parameter  int NUM_SECTORS = 16,
  parameter  int OFFSET_W    = 16,
  localparam int SECT_W      = $clog2(NUM_SECTORS),
  localparam int ADDR_W      = SECT_W + OFFSET_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              top_lock_n,
  input logic              wp_n,
  input logic              lock_wr_en,
  input logic [SECT_W-1:0] lock_wr_sector,
  input logic [1:0]        lock_wr_data,
  input logic              resp_valid,
  input logic              resp_grant,
  input logic              err_flag
);

  localparam logic [SECT_W-1:0] TOP_IDX = SECT_W'(NUM_SECTORS - 1);

  logic [SECT_W-1:0] req_sector;
  assign req_sector = req_addr[ADDR_W-1 -: SECT_W];

  assert_resp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid, 2) && $past(req_op, 2) != 2'b11));

  assert_top_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_grant && $past(req_op, 2) != 2'b00
     && $past(req_sector, 2) == TOP_IDX) |-> $past(top_lock_n, 2));

  assert_wp_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_grant && $past(req_op, 2) != 2'b00
     && $past(req_sector, 2) != TOP_IDX) |-> $past(wp_n, 2));

  assert_deny_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_grant) |-> err_flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> ($past(req_valid, 2) && $past(req_op, 2) == 2'b11));

endmodule

bind sector_guard sector_guard_checker #(
  .NUM_SECTORS(NUM_SECTORS),
  .OFFSET_W   (OFFSET_W)
) u_sector_guard_checker (.*);

// File: tb/sector_guard_bench.sv
module sector_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 16;
  localparam int SW   = 4;
  localparam int AW   = SW + 16;
  localparam int TOP  = NS - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic          top_lock_n, wp_n;
  logic          lock_wr_en;
  logic [SW-1:0] lock_wr_sector;
  logic [1:0]    lock_wr_data;
  logic          resp_valid, resp_grant, err_flag;

  sector_guard u_sector_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  grant;
    logic  err;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;

  // bench-side model state
  logic m_wl [NS];
  logic m_rl [NS];
  logic m_err;

  function automatic void check(string tag, logic act, logic expv, string what);
    n_vec++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endfunction

  // driver: one request per call, held for one cycle
  task automatic issue(input logic [1:0] op, input int sec, input string tag);
    exp_t e;
    logic g;
    logic hw;
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = {SW'(sec), 16'(sec * 16'h0133 + 16'h00a5)};
    if (op == 2'b11) begin
      m_err = 1'b0;
    end else begin
      hw = (sec == TOP) ? top_lock_n : wp_n;
      g  = (op == 2'b00) ? !m_rl[sec] : (hw && !m_wl[sec]);
      if (!g) m_err = 1'b1;
      e.grant = g;
      e.err   = m_err;
      e.tag   = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic lock_write(input int sec, input logic [1:0] d);
    lock_wr_en     = 1'b1;
    lock_wr_sector = SW'(sec);
    lock_wr_data   = d;
    m_wl[sec]      = d[0];
    m_rl[sec]      = d[1];
    @(negedge clk);
    lock_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_fail++;
        $display("FAIL R2 unexpected response: actual resp_valid 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, resp_grant, e.grant, "grant");
        check(e.tag, err_flag, e.err, "err_flag");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0;
    top_lock_n = 1'b1; wp_n = 1'b1;
    lock_wr_en = 1'b0; lock_wr_sector = '0; lock_wr_data = 2'b00;
    for (int i = 0; i < NS; i++) begin m_wl[i] = 1'b1; m_rl[i] = 1'b1; end
    m_err = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state at the ports, then locks prove set
    check("R1", resp_valid, 1'b0, "resp_valid");
    check("R1", err_flag, 1'b0, "err_flag");
    issue(2'b00, 3, "R1 read locked");
    issue(2'b01, TOP, "R1 prog locked");
    idle(3);

    // R8: clear-status drops the flag, with no response (R2)
    issue(2'b11, 0, "R8");
    idle(1);
    check("R8", err_flag, 1'b0, "err after clear");
    idle(2);

    // R9: unlock every sector
    for (int s = 0; s < NS; s++) lock_write(s, 2'b00);

    // R2: latency, exactly two edges
    issue(2'b01, 5, "R2 prog");
    check("R2", resp_valid, 1'b0, "resp_valid after 1 edge");
    idle(2);
    issue(2'b10, TOP, "R5 erase top open");
    idle(2);

    // R3: top pin guards top only, boundary with top-1
    top_lock_n = 1'b0;
    issue(2'b01, TOP, "R3 prog top blocked");
    issue(2'b10, TOP - 1, "R3 erase neighbour free");
    issue(2'b01, 0, "R3 prog low free");
    idle(2);
    issue(2'b11, 0, "R8");
    top_lock_n = 1'b1;
    idle(2);

    // R4: wp pin guards others only
    wp_n = 1'b0;
    issue(2'b10, 0, "R4 erase low blocked");
    issue(2'b01, TOP - 1, "R4 prog neighbour blocked");
    issue(2'b10, TOP, "R4 erase top free");
    // R6: reads ignore pins
    issue(2'b00, 1, "R6 read with wp low");
    idle(2);
    issue(2'b11, 0, "R8");
    wp_n = 1'b1;
    idle(2);

    // R5 and R9: write lock on one sector only
    lock_write(9, 2'b01);
    issue(2'b01, 9, "R5 prog wr-locked");
    issue(2'b00, 9, "R6 read wr-locked");
    issue(2'b01, 8, "R9 neighbour unchanged");
    issue(2'b10, 10, "R9 neighbour unchanged");
    // R8: grants leave the flag set
    issue(2'b00, 2, "R8 sticky");
    idle(2);
    issue(2'b11, 0, "R8");
    idle(2);

    // R6: read lock blocks reads only
    lock_write(4, 2'b10);
    issue(2'b00, 4, "R6 read rd-locked");
    issue(2'b01, 4, "R6 prog rd-locked");
    idle(2);
    issue(2'b11, 0, "R8");
    idle(2);

    // R7: late pin and lock changes do not alter the verdict
    top_lock_n = 1'b1;
    req_valid = 1'b1; req_op = 2'b01; req_addr = {SW'(TOP), 16'h1234};
    exp_q.push_back('{grant: 1'b1, err: m_err, tag: "R7 top pin dropped late"});
    @(negedge clk);
    req_valid = 1'b0;
    top_lock_n = 1'b0;
    idle(2);

    wp_n = 1'b0;
    issue(2'b10, 6, "R7 wp raised late");
    wp_n = 1'b1;
    idle(2);
    issue(2'b11, 0, "R8");
    idle(2);

    issue(2'b01, 7, "R7 lock written late");
    lock_write(7, 2'b11);
    idle(2);
    issue(2'b01, 7, "R7 lock now effective");
    idle(3);
    check("R2", resp_valid, 1'b0, "idle resp_valid");
    check("R2", 1'(exp_q.size() == 0), 1'b1, "queue drained");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule